// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the configuration space of a PCI type-0 function as a byte array and serves byte-addressed reads and writes of one to four bytes. Every header byte carries a fixed write mask, so a write changes only the bits that byte allows. The high byte of the status register clears bits on a written one. Bytes above the 64-byte header are plain storage. An access that is malformed or would run past the end of the space is refused and leaves the space unchanged.

The command register's I/O, memory and bus-master enable bits leave the block as level outputs. Any accepted write that flips the memory enable raises a one-cycle pulse carrying the old and new value. The four base address registers live in a neighbouring block: aligned dword writes to their window are forwarded to it as a pulse with index and data, and their bytes are not stored here. A request is answered one clock after it is presented, whether it is a read or a write.

Top module: `pcicfg_regfile`

## Requirements
- R1: Reset loads vendor ID (bytes 0x00-0x01), device ID (0x02-0x03), revision (0x08), class code (0x09-0x0B) and status (0x06-0x07) from parameters. Every other byte, including the command register and the upper base address halves at 0x24-0x27, reads zero. All three enable outputs are low.
- R2: A request is refused, with rsp_err high and rsp_rdata zero, when req_len is 0 or above 4, or when req_addr + req_len exceeds 256. A refused request changes no byte and raises no pulse.
- R3: rsp_valid is high exactly in the cycle after req_valid. A read returns byte req_addr+i in rsp_rdata[8i+7:8i] for i < req_len, and zeros in the other lanes. Reads change nothing.
- R4: Command low byte 0x04 is fully writable. Of byte 0x05 only bits 2:0 are writable. cmd_io_en, cmd_mem_en and cmd_master_en show bits 0, 1 and 2 of byte 0x04.
- R5: Status byte 0x06 is read-only. In byte 0x07 a one written to a bit under mask 0xF9 clears that bit, and a zero leaves it alone. Bits 1 and 2 of byte 0x07 are read-only.
- R6: Bytes 0x0C, 0x3C and 0x20-0x27 are fully writable. All other header bytes outside R4, R5, R7 and R9 are read-only.
- R7: Expansion ROM base: byte 0x30 has mask 0x01, byte 0x31 has mask 0xF8, and bytes 0x32-0x33 are fully writable.
- R8: Bytes 0x40-0xFF store written data unmasked.
- R9: A write starting in 0x10-0x1F is accepted only with req_addr divisible by 4 and req_len 4. It is then forwarded as a one-cycle bar_wr_valid pulse with bar_wr_idx = (req_addr-0x10)/4 and bar_wr_data = req_wdata, with the response. Bytes 0x10-0x1F are never stored here and read zero.
- R10: Each byte of a multi-byte write follows its own mask and write-one-to-clear rule, independently of its neighbours.
- R11: An accepted write that changes bit 1 of byte 0x04 raises mse_chg for one cycle, together with the response. mse_old and mse_new carry the previous and new bit. A write that leaves the bit unchanged raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the first byte |
| req_len | input | 3 | Number of bytes, 1 to 4 |
| req_wdata | input | 32 | Write data, first byte in bits 7:0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was refused |
| rsp_rdata | output | 32 | Read data, first byte in bits 7:0 |
| cmd_io_en | output | 1 | Command bit 0 |
| cmd_mem_en | output | 1 | Command bit 1 |
| cmd_master_en | output | 1 | Command bit 2 |
| mse_chg | output | 1 | Memory enable changed |
| mse_old | output | 1 | Memory enable before the write |
| mse_new | output | 1 | Memory enable after the write |
| bar_wr_valid | output | 1 | Forwarded base address write |
| bar_wr_idx | output | 2 | Base address register index |
| bar_wr_data | output | 32 | Forwarded write data |

## Verification
A single four-byte write at 0x04 clears the memory enable in the command byte and write-one-clears status bits in byte 0x07. The memory-enable pulse and the status clear therefore fall in the same cycle. The bench first sets the memory enable, then issues that write. It expects the pulse with old value 1 and new value 0 next to the response. A following read must show the status high byte as the old value with only the masked ones removed, while read-only byte 0x06 is untouched.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

    localparam int unsigned CMD_OFF    = 32'h04;
    localparam int unsigned HDR_BYTES  = 32'h40;

    typedef struct packed {
        logic [7:0] mask;
        logic       w1c;
    } byte_attr_t;

    // Writable bits and clear-on-one flag of one configuration byte.
    function automatic byte_attr_t attr_of(input int unsigned off);
        byte_attr_t a;
        a.mask = 8'h00;
        a.w1c  = 1'b0;
        if (off >= HDR_BYTES) begin
            a.mask = 8'hFF;
        end else begin
            case (off)
                32'h04:         a.mask = 8'hFF;
                32'h05:         a.mask = 8'h07;
                32'h07: begin
                                a.mask = 8'hF9;
                                a.w1c  = 1'b1;
                end
                32'h0C:         a.mask = 8'hFF;
                32'h30:         a.mask = 8'h01;
                32'h31:         a.mask = 8'hF8;
                32'h32, 32'h33: a.mask = 8'hFF;
                32'h3C:         a.mask = 8'hFF;
                default: begin
                    if (off >= 32'h20 && off < 32'h28) a.mask = 8'hFF;
                end
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/pcicfg_access_chk.sv
module pcicfg_access_chk #(
    parameter int unsigned CFG_BYTES = 256,
    parameter int unsigned MAX_LEN   = 4,
    parameter int unsigned BAR_BASE  = 16,
    parameter int unsigned BAR_COUNT = 4,
    localparam int unsigned ADDR_W    = $clog2(CFG_BYTES),
    localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1),
    localparam int unsigned BAR_IDX_W = (BAR_COUNT > 1) ? $clog2(BAR_COUNT) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [LEN_W-1:0]     len,
    input  logic                 write,
    output logic                 ok,
    output logic                 bar_hit,
    output logic [BAR_IDX_W-1:0] bar_idx
);
    logic [ADDR_W:0]   end_sum;
    logic [ADDR_W-1:0] rel;
    logic              in_bar;
    logic              len_ok;
    logic              bar_shape_ok;

    always_comb begin
        end_sum      = {1'b0, addr} + (ADDR_W + 1)'(len);
        len_ok       = (len != '0) && (len <= LEN_W'(MAX_LEN));
        in_bar       = (addr >= ADDR_W'(BAR_BASE)) &&
                       (addr <  ADDR_W'(BAR_BASE + 4 * BAR_COUNT));
        rel          = addr - ADDR_W'(BAR_BASE);
        bar_shape_ok = (addr[1:0] == 2'b00) && (len == LEN_W'(4));
        ok           = len_ok && (end_sum <= (ADDR_W + 1)'(CFG_BYTES)) &&
                       !(write && in_bar && !bar_shape_ok);
        bar_hit      = write && in_bar;
        bar_idx      = BAR_IDX_W'(rel >> 2);
    end
endmodule

// File: rtl/pcicfg_byte_merge.sv
module pcicfg_byte_merge
    import pcicfg_pkg::*;
(
    input  logic [7:0] old_byte,
    input  logic [7:0] wr_byte,
    input  byte_attr_t attr,
    output logic [7:0] new_byte
);
    logic [7:0] hit;

    always_comb begin
        hit = wr_byte & attr.mask;
        if (attr.w1c) new_byte = old_byte & ~hit;
        else          new_byte = (old_byte & ~attr.mask) | hit;
    end
endmodule

// File: rtl/pcicfg_regfile.sv
module pcicfg_regfile
    import pcicfg_pkg::*;
#(
    parameter int unsigned CFG_BYTES  = 256,
    parameter int unsigned MAX_LEN    = 4,
    parameter int unsigned BAR_BASE   = 16,
    parameter int unsigned BAR_COUNT  = 4,
    parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID  = 16'h0E17,
    parameter logic [7:0]  REV_ID     = 8'h03,
    parameter logic [23:0] CLASS_CODE = 24'h030000,
    parameter logic [15:0] STATUS_RST = 16'hFA10,
    localparam int unsigned ADDR_W    = $clog2(CFG_BYTES),
    localparam int unsigned LEN_W     = $clog2(MAX_LEN + 1),
    localparam int unsigned DATA_W    = 8 * MAX_LEN,
    localparam int unsigned BAR_IDX_W = (BAR_COUNT > 1) ? $clog2(BAR_COUNT) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 cmd_io_en,
    output logic                 cmd_mem_en,
    output logic                 cmd_master_en,
    output logic                 mse_chg,
    output logic                 mse_old,
    output logic                 mse_new,
    output logic                 bar_wr_valid,
    output logic [BAR_IDX_W-1:0] bar_wr_idx,
    output logic [DATA_W-1:0]    bar_wr_data
);
    typedef logic [CFG_BYTES-1:0][7:0] image_t;

    typedef struct packed {
        image_t                 mem;
        logic                   rsp_valid;
        logic                   rsp_err;
        logic [DATA_W-1:0]      rdata;
        logic                   mse_chg;
        logic                   mse_old;
        logic                   mse_new;
        logic                   bar_valid;
        logic [BAR_IDX_W-1:0]   bar_idx;
        logic [DATA_W-1:0]      bar_data;
    } state_t;

    function automatic image_t reset_image();
        image_t img = '0;
        img[0]  = VENDOR_ID[7:0];
        img[1]  = VENDOR_ID[15:8];
        img[2]  = DEVICE_ID[7:0];
        img[3]  = DEVICE_ID[15:8];
        img[6]  = STATUS_RST[7:0];
        img[7]  = STATUS_RST[15:8];
        img[8]  = REV_ID;
        img[9]  = CLASS_CODE[7:0];
        img[10] = CLASS_CODE[15:8];
        img[11] = CLASS_CODE[23:16];
        return img;
    endfunction

    state_t s_d, s_q;

    logic                 acc_ok;
    logic                 acc_bar;
    logic [BAR_IDX_W-1:0] acc_bar_idx;
    logic [ADDR_W-1:0]    lane_addr [MAX_LEN];
    logic [7:0]           lane_new  [MAX_LEN];

    pcicfg_access_chk #(
        .CFG_BYTES (CFG_BYTES),
        .MAX_LEN   (MAX_LEN),
        .BAR_BASE  (BAR_BASE),
        .BAR_COUNT (BAR_COUNT)
    ) u_chk (
        .addr    (req_addr),
        .len     (req_len),
        .write   (req_write),
        .ok      (acc_ok),
        .bar_hit (acc_bar),
        .bar_idx (acc_bar_idx)
    );

    for (genvar g = 0; g < MAX_LEN; g++) begin : g_lane
        assign lane_addr[g] = req_addr + ADDR_W'(g);
        pcicfg_byte_merge u_merge (
            .old_byte (s_q.mem[lane_addr[g]]),
            .wr_byte  (req_wdata[8*g +: 8]),
            .attr     (attr_of(32'(lane_addr[g]))),
            .new_byte (lane_new[g])
        );
    end

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = req_valid;
        s_d.rsp_err   = 1'b0;
        s_d.rdata     = '0;
        s_d.mse_chg   = 1'b0;
        s_d.mse_old   = 1'b0;
        s_d.mse_new   = 1'b0;
        s_d.bar_valid = 1'b0;
        s_d.bar_idx   = '0;
        s_d.bar_data  = '0;
        if (req_valid) begin
            if (!acc_ok) begin
                s_d.rsp_err = 1'b1;
            end else if (req_write && acc_bar) begin
                s_d.bar_valid = 1'b1;
                s_d.bar_idx   = acc_bar_idx;
                s_d.bar_data  = req_wdata;
            end else if (req_write) begin
                for (int i = 0; i < MAX_LEN; i++) begin
                    if (LEN_W'(i) < req_len) s_d.mem[lane_addr[i]] = lane_new[i];
                end
                if (s_d.mem[CMD_OFF][1] != s_q.mem[CMD_OFF][1]) begin
                    s_d.mse_chg = 1'b1;
                    s_d.mse_old = s_q.mem[CMD_OFF][1];
                    s_d.mse_new = s_d.mem[CMD_OFF][1];
                end
            end else begin
                for (int i = 0; i < MAX_LEN; i++) begin
                    if (LEN_W'(i) < req_len) s_d.rdata[8*i +: 8] = s_q.mem[lane_addr[i]];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q     <= '0;
            s_q.mem <= reset_image();
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid     = s_q.rsp_valid;
    assign rsp_err       = s_q.rsp_err;
    assign rsp_rdata     = s_q.rdata;
    assign cmd_io_en     = s_q.mem[CMD_OFF][0];
    assign cmd_mem_en    = s_q.mem[CMD_OFF][1];
    assign cmd_master_en = s_q.mem[CMD_OFF][2];
    assign mse_chg       = s_q.mse_chg;
    assign mse_old       = s_q.mse_old;
    assign mse_new       = s_q.mse_new;
    assign bar_wr_valid  = s_q.bar_valid;
    assign bar_wr_idx    = s_q.bar_idx;
    assign bar_wr_data   = s_q.bar_data;

    // Response timing
    p_rsp_follows_req_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_spurious_rsp_r3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // Refusal
    p_err_data_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
    p_err_no_change_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> ($stable(s_q.mem) && !mse_chg && !bar_wr_valid));

    // Command high byte keeps its read-only bits at zero
    p_cmd_hi_ro_r4: assert property (@(posedge clk) disable iff (rst)
        s_q.mem[CMD_OFF + 1][7:3] == 5'b0);

    // Status high byte can only lose bits
    p_status_only_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (s_q.mem[7] & ~$past(s_q.mem[7])) == 8'h00);

    // Memory-enable change pulse
    p_mse_pulse_consistent_r11: assert property (@(posedge clk) disable iff (rst)
        mse_chg |-> (mse_old != mse_new && mse_new == cmd_mem_en && rsp_valid && !rsp_err));
    p_mse_after_write_r11: assert property (@(posedge clk) disable iff (rst)
        mse_chg |-> $past(req_valid && req_write));

    // Forwarded base address writes
    p_bar_fwd_accepted_r9: assert property (@(posedge clk) disable iff (rst)
        bar_wr_valid |-> (rsp_valid && !rsp_err && $stable(s_q.mem)));
endmodule

// File: tb/pcicfg_regfile_test.sv
`timescale 1ns/1ps
module pcicfg_regfile_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr  = '0;
    logic [2:0]  req_len   = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        cmd_io_en, cmd_mem_en, cmd_master_en;
    logic        mse_chg, mse_old, mse_new;
    logic        bar_wr_valid;
    logic [1:0]  bar_wr_idx;
    logic [31:0] bar_wr_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic        r_valid, r_err, r_mse, r_old, r_new, r_bar;
    logic [31:0] r_data, r_bdata;
    logic [1:0]  r_idx;

    always #2.5 clk = ~clk;

    pcicfg_regfile #(
        .VENDOR_ID  (16'hA5C3),
        .DEVICE_ID  (16'h0E17),
        .REV_ID     (8'h03),
        .CLASS_CODE (24'h030000),
        .STATUS_RST (16'hFA10)
    ) uut (
        .clk, .rst, .req_valid, .req_write, .req_addr, .req_len, .req_wdata,
        .rsp_valid, .rsp_err, .rsp_rdata, .cmd_io_en, .cmd_mem_en, .cmd_master_en,
        .mse_chg, .mse_old, .mse_new, .bar_wr_valid, .bar_wr_idx, .bar_wr_data
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic acc(input logic wr, input logic [7:0] a, input logic [2:0] l,
                       input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_len = l; req_wdata = d;
        @(negedge clk);
        r_valid = rsp_valid; r_err = rsp_err; r_data = rsp_rdata;
        r_mse = mse_chg; r_old = mse_old; r_new = mse_new;
        r_bar = bar_wr_valid; r_idx = bar_wr_idx; r_bdata = bar_wr_data;
        req_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 enables after reset", {29'b0, cmd_master_en, cmd_mem_en, cmd_io_en}, 32'h0);
        acc(1'b0, 8'h00, 3'd4, 32'h0);
        chk("R3 rsp_valid", {31'b0, r_valid}, 32'h1);
        chk("R1 ids", r_data, 32'h0E17A5C3);
        acc(1'b0, 8'h04, 3'd4, 32'h0);
        chk("R1 command/status", r_data, 32'hFA100000);
        acc(1'b0, 8'h08, 3'd4, 32'h0);
        chk("R1 class/revision", r_data, 32'h03000003);
        acc(1'b0, 8'h24, 3'd4, 32'h0);
        chk("R1 upper base half", r_data, 32'h0);
        acc(1'b0, 8'h3C, 3'd4, 32'h0);
        chk("R1 interrupt dword", r_data, 32'h0);
        @(negedge clk);
        chk("R3 no response without request", {31'b0, rsp_valid}, 32'h0);
    endtask

    task automatic t_command();
        do_reset();
        acc(1'b1, 8'h04, 3'd2, 32'h0000FFFF);
        chk("R11 pulse on set", {29'b0, r_mse, r_old, r_new}, 32'h5);
        chk("R4 enables set", {29'b0, cmd_master_en, cmd_mem_en, cmd_io_en}, 32'h7);
        acc(1'b0, 8'h04, 3'd2, 32'h0);
        chk("R4 command mask", r_data, 32'h000007FF);
        acc(1'b1, 8'h04, 3'd1, 32'h000000FD);
        chk("R11 pulse on clear", {29'b0, r_mse, r_old, r_new}, 32'h6);
        chk("R4 mem enable cleared", {29'b0, cmd_master_en, cmd_mem_en, cmd_io_en}, 32'h5);
        acc(1'b1, 8'h04, 3'd1, 32'h000000FD);
        chk("R11 no pulse when unchanged", {31'b0, r_mse}, 32'h0);
    endtask

    task automatic t_status();
        do_reset();
        acc(1'b1, 8'h07, 3'd1, 32'h00000008);
        acc(1'b0, 8'h06, 3'd2, 32'h0);
        chk("R5 single bit clear", r_data, 32'h0000F210);
        acc(1'b1, 8'h06, 3'd1, 32'h000000FF);
        acc(1'b0, 8'h06, 3'd2, 32'h0);
        chk("R5 low byte read-only", r_data, 32'h0000F210);
        acc(1'b1, 8'h07, 3'd1, 32'h00000000);
        acc(1'b0, 8'h06, 3'd2, 32'h0);
        chk("R5 zero has no effect", r_data, 32'h0000F210);
        acc(1'b1, 8'h07, 3'd1, 32'h000000FF);
        acc(1'b0, 8'h06, 3'd2, 32'h0);
        chk("R5 read-only bits survive", r_data, 32'h00000210);
    endtask

    task automatic t_same_cycle();
        do_reset();
        acc(1'b1, 8'h04, 3'd1, 32'h00000002);
        acc(1'b1, 8'h04, 3'd4, 32'h81000000);
        chk("R11 pulse with status clear", {29'b0, r_mse, r_old, r_new}, 32'h6);
        chk("R10 write accepted", {30'b0, r_valid, r_err}, 32'h2);
        acc(1'b0, 8'h04, 3'd4, 32'h0);
        chk("R10 per-byte result", r_data, 32'h7A100000);
    endtask

    task automatic t_header_masks();
        do_reset();
        acc(1'b1, 8'h0C, 3'd1, 32'h000000AB);
        acc(1'b1, 8'h0D, 3'd1, 32'h000000FF);
        acc(1'b0, 8'h0C, 3'd2, 32'h0);
        chk("R6 cache line writable, next read-only", r_data, 32'h000000AB);
        acc(1'b1, 8'h3C, 3'd4, 32'hFFFFFFFF);
        acc(1'b0, 8'h3C, 3'd4, 32'h0);
        chk("R6 interrupt line only", r_data, 32'h000000FF);
        acc(1'b1, 8'h00, 3'd4, 32'hFFFFFFFF);
        acc(1'b0, 8'h00, 3'd4, 32'h0);
        chk("R6 ids read-only", r_data, 32'h0E17A5C3);
        acc(1'b1, 8'h20, 3'd4, 32'h12345678);
        acc(1'b0, 8'h20, 3'd4, 32'h0);
        chk("R6 0x20 writable", r_data, 32'h12345678);
    endtask

    task automatic t_rom();
        do_reset();
        acc(1'b1, 8'h30, 3'd4, 32'hFFFFFFFF);
        acc(1'b0, 8'h30, 3'd4, 32'h0);
        chk("R7 rom masks", r_data, 32'hFFFFF801);
        acc(1'b1, 8'h30, 3'd4, 32'h00000000);
        acc(1'b0, 8'h30, 3'd4, 32'h0);
        chk("R7 rom cleared", r_data, 32'h0);
    endtask

    task automatic t_direct();
        do_reset();
        acc(1'b1, 8'h40, 3'd4, 32'hDEADBEEF);
        acc(1'b0, 8'h41, 3'd3, 32'h0);
        chk("R3 three-byte packing", r_data, 32'h00DEADBE);
        acc(1'b1, 8'hFC, 3'd4, 32'h01020304);
        acc(1'b0, 8'hFE, 3'd2, 32'h0);
        chk("R8 top bytes", r_data, 32'h00000102);
        acc(1'b0, 8'hFF, 3'd1, 32'h0);
        chk("R3 last byte", r_data, 32'h00000001);
        acc(1'b0, 8'h40, 3'd4, 32'h0);
        chk("R3 read has no side effect", r_data, 32'hDEADBEEF);
    endtask

    task automatic t_reject();
        do_reset();
        acc(1'b1, 8'hFC, 3'd4, 32'h01020304);
        acc(1'b1, 8'hFE, 3'd4, 32'hFFFFFFFF);
        chk("R2 overrun write refused", {31'b0, r_err}, 32'h1);
        acc(1'b0, 8'hFC, 3'd4, 32'h0);
        chk("R2 overrun write no effect", r_data, 32'h01020304);
        acc(1'b0, 8'hFE, 3'd4, 32'h0);
        chk("R2 overrun read", {r_data[30:0], r_err}, 32'h1);
        acc(1'b0, 8'h00, 3'd0, 32'h0);
        chk("R2 zero length", {31'b0, r_err}, 32'h1);
        acc(1'b1, 8'h04, 3'd5, 32'hFFFFFFFF);
        chk("R2 length five", {30'b0, r_err, r_mse}, 32'h2);
        chk("R2 no enable change", {29'b0, cmd_master_en, cmd_mem_en, cmd_io_en}, 32'h0);
        acc(1'b1, 8'h11, 3'd1, 32'h000000FF);
        chk("R9 unaligned base write", {30'b0, r_err, r_bar}, 32'h2);
        acc(1'b1, 8'h10, 3'd2, 32'h0000FFFF);
        chk("R9 short base write", {30'b0, r_err, r_bar}, 32'h2);
    endtask

    task automatic t_bar();
        do_reset();
        acc(1'b1, 8'h18, 3'd4, 32'hCAFE0008);
        chk("R9 forward pulse", {29'b0, r_err, r_bar, 1'b0}, 32'h2);
        chk("R9 forward index", {30'b0, r_idx}, 32'h2);
        chk("R9 forward data", r_bdata, 32'hCAFE0008);
        acc(1'b0, 8'h18, 3'd4, 32'h0);
        chk("R9 not stored", r_data, 32'h0);
        acc(1'b1, 8'h0E, 3'd4, 32'hFFFFFFFF);
        chk("R9 spanning write not forwarded", {30'b0, r_err, r_bar}, 32'h0);
        acc(1'b0, 8'h0C, 3'd4, 32'h0);
        chk("R9 spanning write leaves header", r_data, 32'h0);
        acc(1'b0, 8'h10, 3'd4, 32'h0);
        chk("R9 window reads zero", r_data, 32'h0);
    endtask

    task automatic t_reset_restores();
        acc(1'b1, 8'h40, 3'd4, 32'h55AA55AA);
        acc(1'b1, 8'h04, 3'd1, 32'h00000007);
        acc(1'b1, 8'h07, 3'd1, 32'h000000FF);
        do_reset();
        chk("R1 enables low again", {29'b0, cmd_master_en, cmd_mem_en, cmd_io_en}, 32'h0);
        acc(1'b0, 8'h40, 3'd4, 32'h0);
        chk("R1 storage cleared", r_data, 32'h0);
        acc(1'b0, 8'h06, 3'd2, 32'h0);
        chk("R1 status restored", r_data, 32'h0000FA10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_command();
        t_status();
        t_same_cycle();
        t_header_masks();
        t_rom();
        t_direct();
        t_reject();
        t_bar();
        t_reset_restores();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule